// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block moves an operand one bit position to the left or to the right. The vacated end is filled with one bit picked by a three-bit fill code. The fill can be the incoming carry flag, the operand's top bit, the operand's bottom bit, a constant 0 or a constant 1. One mechanism therefore covers several instructions:

- logical shifts, with a constant fill;
- shifts that set the vacated bit to 1;
- sign-extending right shifts, with the top bit as fill;
- shifts through the carry;
- rotates in both directions, with the opposite end of the operand as fill.

The bit pushed out of the operand becomes the new carry. A zero flag reports an all-zero result.

The direction arrives in a field whose bottom bit alone selects the direction. The upper bits are padding from the surrounding instruction word and carry no meaning. All three outputs are registered. A result appears on the outputs one clock after its operands are presented, and a fresh result follows on every clock. Instruction decoding and register write-back belong to the surrounding datapath.

Top module: `shrot_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `result`=0, `carry_out`=0 and `zero_out`=0.
- R2: With `dir[0]`=0 (left), `result` = {`op_a`[W-2:0], fill} and `carry_out` = `op_a`[W-1].
- R3: With `dir[0]`=1 (right), `result` = {fill, `op_a`[W-1:1]} and `carry_out` = `op_a`[0].
- R4: Bits of `dir` above bit 0 have no effect on any output.
- R5: Fill codes 3'b000 and 3'b001 use `carry_in` as the fill bit.
- R6: Fill codes 3'b010 and 3'b011 use `op_a`[W-1] as the fill bit. This gives a sign-extending right shift and a left rotate.
- R7: Fill codes 3'b100 and 3'b101 use `op_a`[0] as the fill bit. This gives a right rotate.
- R8: Fill code 3'b110 fills with 0 and 3'b111 fills with 1.
- R9: `zero_out` is 1 exactly when the registered `result` is all zeros (outside reset).
- R10: Outputs reflect the inputs sampled at the previous rising edge: one cycle of latency, with a new result every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | DATA_W | Operand to shift |
| carry_in | input | 1 | Current carry flag |
| dir | input | DIR_W | Direction field; bit 0: 0 = left, 1 = right |
| fill_sel | input | 3 | Fill source code |
| result | output | DATA_W | Registered shifted value |
| carry_out | output | 1 | Registered bit shifted out |
| zero_out | output | 1 | Registered all-zero flag of result |

## Verification
The bench builds the unit with the default DATA_W=8 and DIR_W=2. The two-bit direction field means a padding bit really exists, so the bench can set it and show that it has no effect in both directions. The 8-bit width lets hand-picked operands cover several cases: the bottom bit moving into the top in a right rotate, a lone set bit falling off either end into an all-zero result, and top bits of both values feeding the sign-extending fill.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  // Fill source, decoded from the upper two bits of the fill code.
  typedef enum logic [1:0] {
    FS_CARRY = 2'b00,
    FS_MSB   = 2'b01,
    FS_LSB   = 2'b10,
    FS_CONST = 2'b11
  } fill_src_e;

  localparam int FILL_SEL_W = 3;

endpackage

// File: rtl/shrot_fill_sel.sv
module shrot_fill_sel
  import shrot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]     operand,
  input  logic                  carry_in,
  input  logic [FILL_SEL_W-1:0] fill_sel,
  output logic                  fill_bit
);

  fill_src_e src;

  assign src = fill_src_e'(fill_sel[FILL_SEL_W-1:1]);

  always_comb begin
    case (src)
      FS_CARRY: fill_bit = carry_in;
      FS_MSB:   fill_bit = operand[DATA_W-1];
      FS_LSB:   fill_bit = operand[0];
      default:  fill_bit = fill_sel[0];
    endcase
  end

endmodule

// File: rtl/shrot_core.sv
module shrot_core #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              fill_bit,
  input  logic              go_right,
  output logic [DATA_W-1:0] shifted,
  output logic              spill
);

  localparam int TOP = DATA_W - 1;

  // Per-bit two-way mux: neighbour below for left, neighbour above for right.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_low_end
      assign from_low = fill_bit;
    end else begin : g_low_mid
      assign from_low = operand[i-1];
    end
    if (i == TOP) begin : g_high_end
      assign from_high = fill_bit;
    end else begin : g_high_mid
      assign from_high = operand[i+1];
    end
    assign shifted[i] = go_right ? from_high : from_low;
  end

  assign spill = go_right ? operand[0] : operand[TOP];

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIR_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DATA_W-1:0]     op_a,
  input  logic                  carry_in,
  input  logic [DIR_W-1:0]      dir,
  input  logic [FILL_SEL_W-1:0] fill_sel,
  output logic [DATA_W-1:0]     result,
  output logic                  carry_out,
  output logic                  zero_out
);

  localparam int TOP = DATA_W - 1;

  logic              fill_bit;
  logic [DATA_W-1:0] shifted;
  logic              spill;

  shrot_fill_sel #(.DATA_W(DATA_W)) u_fill (
    .operand  (op_a),
    .carry_in (carry_in),
    .fill_sel (fill_sel),
    .fill_bit (fill_bit)
  );

  shrot_core #(.DATA_W(DATA_W)) u_core (
    .operand  (op_a),
    .fill_bit (fill_bit),
    .go_right (dir[0]),
    .shifted  (shifted),
    .spill    (spill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      zero_out  <= 1'b0;
    end else begin
      result    <= shifted;
      carry_out <= spill;
      zero_out  <= ~|shifted;
    end
  end

  // Assertions
  AST_LEFT_SPILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dir[0])) |-> (carry_out == $past(op_a[TOP])));  // R2

  AST_RIGHT_SPILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dir[0])) |-> (carry_out == $past(op_a[0])));  // R3

  AST_CARRY_FILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fill_sel[2:1]) == 2'b00 && !$past(dir[0]))
      |-> (result[0] == $past(carry_in)));  // R5

  AST_MSB_FILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fill_sel[2:1]) == 2'b01 && $past(dir[0]))
      |-> (result[TOP] == $past(op_a[TOP])));  // R6

  AST_ROTATE_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fill_sel[2:1]) == 2'b10 && $past(dir[0]))
      |-> (result[TOP] == $past(op_a[0])));  // R7

  AST_CONST_FILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fill_sel[2:1]) == 2'b11 && !$past(dir[0]))
      |-> (result[0] == $past(fill_sel[0])));  // R8

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (zero_out == (result == '0)));  // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !carry_out && !zero_out));  // R1

  if (DIR_W > 1) begin : g_pad_chk
    AST_PAD_NOEFFECT: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(dir[DIR_W-1:1]) != '0)
        |-> (carry_out == ($past(dir[0]) ? $past(op_a[0]) : $past(op_a[TOP]))));  // R4
  end

endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;

  localparam int DATA_W = 8;
  localparam int DIR_W  = 2;
  localparam int NV     = 17;

  logic              clk = 1'b0;
  logic              rst;
  logic [DATA_W-1:0] op_a;
  logic              carry_in;
  logic [DIR_W-1:0]  dir;
  logic [2:0]        fill_sel;
  logic [DATA_W-1:0] result;
  logic              carry_out;
  logic              zero_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  shrot_unit #(.DATA_W(DATA_W), .DIR_W(DIR_W)) u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .carry_in(carry_in), .dir(dir),
    .fill_sel(fill_sel), .result(result), .carry_out(carry_out), .zero_out(zero_out)
  );

  // {op_a, carry_in, dir, fill_sel, exp_result, exp_carry, exp_zero}
  localparam logic [23:0] VEC [NV] = '{
    {8'h96, 1'b0, 2'b00, 3'b110, 8'h2C, 1'b1, 1'b0},  // left, fill 0
    {8'h96, 1'b0, 2'b00, 3'b111, 8'h2D, 1'b1, 1'b0},  // left, fill 1
    {8'h96, 1'b0, 2'b00, 3'b100, 8'h2C, 1'b1, 1'b0},  // left, fill lsb
    {8'h96, 1'b1, 2'b00, 3'b000, 8'h2D, 1'b1, 1'b0},  // left through carry
    {8'h96, 1'b0, 2'b00, 3'b010, 8'h2D, 1'b1, 1'b0},  // rotate left
    {8'h96, 1'b0, 2'b01, 3'b110, 8'h4B, 1'b0, 1'b0},  // right, fill 0
    {8'h96, 1'b0, 2'b01, 3'b111, 8'hCB, 1'b0, 1'b0},  // right, fill 1
    {8'h96, 1'b0, 2'b01, 3'b010, 8'hCB, 1'b0, 1'b0},  // sign extend
    {8'h96, 1'b1, 2'b01, 3'b001, 8'hCB, 1'b0, 1'b0},  // right through carry
    {8'h96, 1'b0, 2'b01, 3'b100, 8'h4B, 1'b0, 1'b0},  // rotate right, lsb 0
    {8'h01, 1'b0, 2'b01, 3'b101, 8'h80, 1'b1, 1'b0},  // rotate right, lsb 1
    {8'h80, 1'b0, 2'b00, 3'b110, 8'h00, 1'b1, 1'b1},  // bit falls off left
    {8'h01, 1'b0, 2'b11, 3'b110, 8'h00, 1'b1, 1'b1},  // padding set, right
    {8'h96, 1'b0, 2'b10, 3'b111, 8'h2D, 1'b1, 1'b0},  // padding set, left
    {8'h00, 1'b1, 2'b00, 3'b000, 8'h01, 1'b0, 1'b0},  // carry into zero operand
    {8'h40, 1'b0, 2'b00, 3'b011, 8'h80, 1'b0, 1'b0},  // rotate left, msb 0
    {8'h7F, 1'b0, 2'b01, 3'b011, 8'h3F, 1'b1, 1'b0}   // sign extend positive
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic c, input logic [1:0] d,
                       input logic [2:0] s);
    @(negedge clk);
    op_a = a; carry_in = c; dir = d; fill_sel = s;
    @(posedge clk);
    #1;
  endtask

  function automatic string fill_req(input logic [2:0] s);
    case (s[2:1])
      2'b00:   return "R5";
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; op_a = 8'hFF; carry_in = 1'b1; dir = 2'b00; fill_sel = 3'b111;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 result", result, 0);
    check("R1 carry", carry_out, 0);
    check("R1 zero", zero_out, 0);

    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      string dreq;
      v = VEC[i];
      drive(v[23:16], v[15], v[14:13], v[12:10]);
      dreq = v[13] ? "R3" : "R2";
      if (v[14]) dreq = {dreq, "/R4"};
      check({dreq, "/", fill_req(v[12:10]), " result"}, result, v[9:2]);
      check({dreq, " carry"}, carry_out, v[1]);
      check("R9 zero", zero_out, v[0]);
    end

    // R10: output holds old value before the edge, updates right after it
    drive(8'h96, 1'b0, 2'b00, 3'b110);
    @(negedge clk);
    op_a = 8'h01; dir = 2'b01; fill_sel = 3'b101;
    #1;
    check("R10 before edge", result, 8'h2C);
    @(posedge clk);
    #1;
    check("R10 after edge", result, 8'h80);
    check("R10 carry", carry_out, 1);

    // R9: zero flag then clears on a non-zero result
    drive(8'h80, 1'b0, 2'b00, 3'b110);
    check("R9 zero set", zero_out, 1);
    drive(8'h80, 1'b0, 2'b00, 3'b111);
    check("R9 zero clear", zero_out, 0);
    check("R8 fill one", result, 8'h01);

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1; op_a = 8'h96; dir = 2'b00; fill_sel = 3'b111;
    @(posedge clk);
    #1;
    check("R1 mid result", result, 0);
    check("R1 mid carry", carry_out, 0);
    check("R1 mid zero", zero_out, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule